// File: doc/BRIEF.md
# Center-Aligned PWM Bank with Pair Concatenation

This block generates six pulse-width modulated outputs. Each channel has a period value, a duty value, a polarity bit, an enable and a clock-enable tick from an external prescaler. The channel counter runs up and then back down, so the pulse sits symmetrically about the middle of each period, and one output period spans twice the period value in ticks.

Neighbouring channels can be fused in pairs (0 with 1, 2 with 3, 4 with 5) into one 16-bit channel. The even channel then supplies the upper byte of period and duty, the odd channel the lower byte. The odd channel's tick, enable and polarity run the fused channel, its pin carries the waveform, and the even pin rests at its idle level. Period and duty are taken into use only at a period boundary or while the channel is off, so a running period is never disturbed by a write.

Top module: `cpwm_bank`

## Requirements
- R1: A channel's state advances only on a clock edge where its tick input is 1. The counter visits 0,1,...,P-1 and then P-1,...,0, so one output period lasts 2*P ticks (P = period value) and is symmetric about its middle; the first enabled cycle is phase 0.
- R2: With polarity 0 and 0 < D <= P, the pin is high for 2*(P-D) ticks of each period (high while the counter is >= D); with D >= P it stays low.
- R3: With polarity 1 the pin is high for 2*D ticks of each period (high while the counter is < D); D >= P keeps it high and D = 0 keeps it low.
- R4: With P = 4, D = 1, polarity 0 and a tick every cycle, the pin repeats every 8 cycles and is high for 6 of them, low in the first and last phase.
- R5: While a channel is disabled, and out of reset, its pin is at the idle level: the inverse of its polarity bit (high for polarity 0, low for polarity 1); on re-enable the waveform restarts at phase 0.
- R6: An enabled channel whose active period is 0 holds its pin at the idle level; a nonzero period written later is taken on the next tick and the waveform starts at phase 0 on the following cycle.
- R7: Period and duty inputs are copied into use only while the channel is disabled, on a tick while the active period is 0, or on the tick that ends a period; a change in mid-period affects the following period only.
- R8: Bit k of `cat_i` fuses channels 2k and 2k+1: period and duty become {even byte, odd byte}, the odd channel's tick, enable and polarity control the result, which appears on pin 2k+1; pin 2k is held at the inverse of polarity bit 2k and the even channel's tick and enable have no effect. `cat_i` is changed only while both channels of the pair are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 6 | Per-channel count enable, bit i for channel i |
| en_i | input | 6 | Per-channel enable, bit i for channel i |
| pol_i | input | 6 | Per-channel polarity, bit i for channel i |
| per_i | input | 48 | Period values, channel i in bits [8i+7:8i] |
| dty_i | input | 48 | Duty values, channel i in bits [8i+7:8i] |
| cat_i | input | 3 | Pair fuse bits, bit k joins channels 2k and 2k+1 |
| pwm_o | output | 6 | PWM pins, bit i for channel i |

## Verification
The waveform is checked cycle by cycle against a phase model for both polarities with duty inside the period, at zero and at or above the period, which separates the high-while-below rule from the high-while-at-or-above rule and exposes off-by-one turnaround errors. A sparse tick pattern shows the counter stepping only on ticks, while a zero period and a mid-period duty change show when new values are taken. Fused pairs are run with periods whose bytes differ, so a swapped byte order, a wrong controlling channel or a leaking even pin all change the observed pins.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} dir_e;
endpackage

// File: rtl/cpwm_chan.sv
module cpwm_chan
  import cpwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] dty_o,
  output logic         live_o
);
  logic [W-1:0] cnt_q, per_q, dty_q;
  dir_e         dir_q;
  logic         at_top, per_zero;

  assign per_zero = (per_q == '0);
  assign at_top   = (cnt_q == per_q - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      dty_q <= '0;
      dir_q <= DIR_UP;
    end else if (!en_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= per_i;
      dty_q <= dty_i;
    end else if (tick_i) begin
      if (per_zero) begin
        per_q <= per_i;
        dty_q <= dty_i;
      end else if (dir_q == DIR_UP) begin
        if (at_top) dir_q <= DIR_DN;   // top value is held for one extra tick
        else        cnt_q <= cnt_q + W'(1);
      end else if (cnt_q == '0) begin
        dir_q <= DIR_UP;               // period boundary: take new values
        per_q <= per_i;
        dty_q <= dty_i;
      end else begin
        cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign dty_o  = dty_q;
  assign live_o = en_i && !per_zero;
endmodule

// File: rtl/cpwm_out.sv
module cpwm_out #(
  parameter int unsigned W = 8
) (
  input  logic         pol_i,
  input  logic         live_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] dty_i,
  output logic         pin_o
);
  logic below;
  assign below = (cnt_i < dty_i);

  always_comb begin
    if (!live_i) pin_o = ~pol_i;
    else         pin_o = pol_i ? below : ~below;
  end
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     tick_i,
  input  logic [1:0]     en_i,
  input  logic [1:0]     pol_i,
  input  logic [2*W-1:0] per_i,
  input  logic [2*W-1:0] dty_i,
  input  logic           cat_i,
  output logic [1:0]     pin_o
);
  localparam int unsigned WW = 2 * W;

  logic [1:0] nar_pin;

  for (genvar g = 0; g < 2; g++) begin : g_nar
    logic [W-1:0] cnt, dty;
    logic         live;

    cpwm_chan #(.W(W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i[g]),
      .en_i   (en_i[g] && !cat_i),
      .per_i  (per_i[g*W +: W]),
      .dty_i  (dty_i[g*W +: W]),
      .cnt_o  (cnt),
      .dty_o  (dty),
      .live_o (live)
    );

    cpwm_out #(.W(W)) u_out (
      .pol_i  (pol_i[g]),
      .live_i (live),
      .cnt_i  (cnt),
      .dty_i  (dty),
      .pin_o  (nar_pin[g])
    );
  end

  // fused channel: even byte is the upper half, odd channel controls
  logic [WW-1:0] w_per, w_dty, w_cnt, w_dty_act;
  logic          w_live, w_pin;

  assign w_per = {per_i[W-1:0], per_i[WW-1:W]};
  assign w_dty = {dty_i[W-1:0], dty_i[WW-1:W]};

  cpwm_chan #(.W(WW)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i[1]),
    .en_i   (en_i[1] && cat_i),
    .per_i  (w_per),
    .dty_i  (w_dty),
    .cnt_o  (w_cnt),
    .dty_o  (w_dty_act),
    .live_o (w_live)
  );

  cpwm_out #(.W(WW)) u_wide_out (
    .pol_i  (pol_i[1]),
    .live_i (w_live),
    .cnt_i  (w_cnt),
    .dty_i  (w_dty_act),
    .pin_o  (w_pin)
  );

  assign pin_o[0] = nar_pin[0];
  assign pin_o[1] = cat_i ? w_pin : nar_pin[1];
endmodule

// File: rtl/cpwm_bank.sv
module cpwm_bank #(
  parameter int unsigned NUM_PAIRS = 3,
  parameter int unsigned CH_W      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2*NUM_PAIRS-1:0]        tick_i,
  input  logic [2*NUM_PAIRS-1:0]        en_i,
  input  logic [2*NUM_PAIRS-1:0]        pol_i,
  input  logic [2*NUM_PAIRS*CH_W-1:0]   per_i,
  input  logic [2*NUM_PAIRS*CH_W-1:0]   dty_i,
  input  logic [NUM_PAIRS-1:0]          cat_i,
  output logic [2*NUM_PAIRS-1:0]        pwm_o
);
  localparam int unsigned PW = 2 * CH_W;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    cpwm_pair #(.W(CH_W)) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i[2*k +: 2]),
      .en_i   (en_i[2*k +: 2]),
      .pol_i  (pol_i[2*k +: 2]),
      .per_i  (per_i[k*PW +: PW]),
      .dty_i  (dty_i[k*PW +: PW]),
      .cat_i  (cat_i[k]),
      .pin_o  (pwm_o[2*k +: 2])
    );
  end
endmodule

// File: rtl/cpwm_bank_chk.sv
module cpwm_bank_chk #(
  parameter int unsigned NUM_PAIRS = 3,
  parameter int unsigned CH_W      = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [2*NUM_PAIRS-1:0]      tick_i,
  input logic [2*NUM_PAIRS-1:0]      en_i,
  input logic [2*NUM_PAIRS-1:0]      pol_i,
  input logic [2*NUM_PAIRS*CH_W-1:0] per_i,
  input logic [2*NUM_PAIRS*CH_W-1:0] dty_i,
  input logic [NUM_PAIRS-1:0]        cat_i,
  input logic [2*NUM_PAIRS-1:0]      pwm_o
);
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pk
    localparam int E = 2 * k;
    localparam int O = 2 * k + 1;

    AST_IDLE_ODD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[O] |-> pwm_o[O] == ~pol_i[O]); // R5

    AST_IDLE_EVEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[E] |-> pwm_o[E] == ~pol_i[E]); // R5

    AST_FUSED_EVEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cat_i[k] |-> pwm_o[E] == ~pol_i[E]); // R8

    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int C = 2 * k + s;

      AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i[C] |=> (!($stable(en_i[C]) && $stable(pol_i[C]) && $stable(cat_i[k]))
                        || $stable(pwm_o[C]))); // R1

      AST_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(en_i[C]) && !cat_i[k] && $stable(cat_i[k])
         && $stable(per_i[C*CH_W +: CH_W]) && $stable(dty_i[C*CH_W +: CH_W])
         && per_i[C*CH_W +: CH_W] != '0)
        |-> pwm_o[C] == (pol_i[C] ? (dty_i[C*CH_W +: CH_W] != '0)
                                  : (dty_i[C*CH_W +: CH_W] == '0))); // R3
    end
  end
endmodule

bind cpwm_bank cpwm_bank_chk #(.NUM_PAIRS(NUM_PAIRS), .CH_W(CH_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .en_i   (en_i),
  .pol_i  (pol_i),
  .per_i  (per_i),
  .dty_i  (dty_i),
  .cat_i  (cat_i),
  .pwm_o  (pwm_o)
);

// File: tb/cpwm_bank_tb_top.sv
`timescale 1ns/1ps
module cpwm_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  tick = 6'h3F, en = '0, pol = '0;
  logic [2:0]  cat = '0;
  logic [7:0]  per [6];
  logic [7:0]  dty [6];
  logic [47:0] per_flat, dty_flat;
  logic [5:0]  pwm;

  int checks = 0, failures = 0;
  logic [5:0] q_v[$];
  string      q_t[$];
  string      tag = "R5";

  // model state
  int m_ph[6], m_per[6], m_dty[6];
  int w_ph[3], w_per[3], w_dty[3];

  always #4 clk = ~clk; // 125 MHz

  always_comb begin
    for (int i = 0; i < 6; i++) begin
      per_flat[8*i +: 8] = per[i];
      dty_flat[8*i +: 8] = dty[i];
    end
  end

  cpwm_bank dut_i (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .en_i (en), .pol_i (pol),
    .per_i (per_flat), .dty_i (dty_flat), .cat_i (cat), .pwm_o (pwm)
  );

  function automatic logic wave(int p, int pr, int d, logic pl);
    int c;
    if (pr == 0) return ~pl;
    c = (p < pr) ? p : 2 * pr - 1 - p;
    return pl ? (c < d) : (c >= d);
  endfunction

  function automatic logic [5:0] expect_vec();
    logic [5:0] v;
    for (int k = 0; k < 3; k++) begin
      if (cat[k]) begin
        v[2*k]   = ~pol[2*k];
        v[2*k+1] = en[2*k+1] ? wave(w_ph[k], w_per[k], w_dty[k], pol[2*k+1]) : ~pol[2*k+1];
      end else begin
        for (int s = 0; s < 2; s++) begin
          int i = 2 * k + s;
          v[i] = en[i] ? wave(m_ph[i], m_per[i], m_dty[i], pol[i]) : ~pol[i];
        end
      end
    end
    return v;
  endfunction

  task automatic model_edge();
    for (int i = 0; i < 6; i++) begin
      if (!(en[i] && !cat[i/2])) begin
        m_ph[i] = 0; m_per[i] = per[i]; m_dty[i] = dty[i];
      end else if (tick[i]) begin
        if (m_per[i] == 0) begin m_per[i] = per[i]; m_dty[i] = dty[i]; end
        else begin
          m_ph[i]++;
          if (m_ph[i] == 2 * m_per[i]) begin m_ph[i] = 0; m_per[i] = per[i]; m_dty[i] = dty[i]; end
        end
      end
    end
    for (int k = 0; k < 3; k++) begin
      int np = {per[2*k], per[2*k+1]};
      int nd = {dty[2*k], dty[2*k+1]};
      if (!(en[2*k+1] && cat[k])) begin
        w_ph[k] = 0; w_per[k] = np; w_dty[k] = nd;
      end else if (tick[2*k+1]) begin
        if (w_per[k] == 0) begin w_per[k] = np; w_dty[k] = nd; end
        else begin
          w_ph[k]++;
          if (w_ph[k] == 2 * w_per[k]) begin w_ph[k] = 0; w_per[k] = np; w_dty[k] = nd; end
        end
      end
    end
  endtask

  // driver: push expectation for this cycle, advance the model, move to next cycle
  task automatic step(int n);
    for (int j = 0; j < n; j++) begin
      q_v.push_back(expect_vec());
      q_t.push_back(tag);
      model_edge();
      @(posedge clk); #1;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_v.size() > 0) begin
      logic [5:0] e;
      string t;
      e = q_v.pop_front();
      t = q_t.pop_front();
      checks++;
      if (pwm !== e) begin
        failures++;
        $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, pwm, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin per[i] = '0; dty[i] = '0; end
    for (int i = 0; i < 6; i++) begin m_ph[i] = 0; m_per[i] = 0; m_dty[i] = 0; end
    for (int k = 0; k < 3; k++) begin w_ph[k] = 0; w_per[k] = 0; w_dty[k] = 0; end
    #10;
    checks++; // R5: reset idle level, polarity 0 -> high
    if (pwm !== 6'h3F) begin failures++; $display("FAIL R5 reset actual=%b expected=%b", pwm, 6'h3F); end
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1;
    tag = "R5 idle after reset"; step(3);

    // R4: worked example
    per[0] = 4; dty[0] = 1; step(1);
    en[0] = 1'b1; tag = "R4 P4 D1 pol0"; step(24);
    en = '0; step(2);

    // R2: polarity 0, duty inside and at/above period
    per[1] = 6; dty[1] = 2; per[4] = 5; dty[4] = 5; per[5] = 3; dty[5] = 9; step(1);
    en[1] = 1; en[4] = 1; en[5] = 1; tag = "R2 pol0"; step(30);
    en = '0; step(2);

    // R3: polarity 1, duty inside, above period and zero
    pol[2] = 1; pol[3] = 1; pol[5] = 1;
    per[2] = 5; dty[2] = 2; per[3] = 3; dty[3] = 7; per[5] = 4; dty[5] = 0; step(1);
    en[2] = 1; en[3] = 1; en[5] = 1; tag = "R3 pol1"; step(30);
    en = '0; pol = '0; step(2);

    // R1: sparse ticks on channel 0, odd ticks on channel 1
    per[0] = 3; dty[0] = 1; pol[0] = 1; per[1] = 7; dty[1] = 3; step(1);
    en[0] = 1; en[1] = 1; tag = "R1 tick gating";
    for (int j = 0; j < 40; j++) begin
      tick[0] = (j % 2 == 0);
      tick[1] = (j % 3 == 0);
      step(1);
    end
    tick = 6'h3F; en = '0; pol = '0; step(2);

    // R6: zero period holds idle, then a nonzero value is picked up
    per[1] = 0; dty[1] = 1; pol[1] = 1; step(1);
    en[1] = 1; tag = "R6 zero period pol1"; step(5);
    pol[1] = 0; tag = "R6 zero period pol0"; step(5);
    per[1] = 3; tag = "R6 period taken on tick"; step(14);
    en = '0; step(2);

    // R7: mid-period change waits for the period boundary
    per[4] = 4; dty[4] = 1; pol[4] = 1; step(1);
    en[4] = 1; tag = "R7 shadow"; step(3);
    dty[4] = 3; step(2);
    per[4] = 2; step(20);
    // R5: disable mid-run, then restart at phase 0
    en[4] = 0; tag = "R5 disable mid-run"; step(3);
    en[4] = 1; tag = "R5 restart"; step(10);
    en = '0; pol = '0; step(2);

    // R8: fused pair 2/3, byte order and control from odd channel
    cat[1] = 1; step(1);
    per[2] = 8'h01; per[3] = 8'h02; dty[2] = 8'h00; dty[3] = 8'h81; pol[3] = 1; pol[2] = 1;
    tick[2] = 0; step(1);
    en[3] = 1; en[2] = 1; tag = "R8 fused 2/3"; step(600);
    en = '0; step(2);
    cat[1] = 0; tick = 6'h3F; pol = '0; step(2);

    // R8: fused pair 0/1 with period 0x0005, then 0x0100 vs swapped
    cat[0] = 1; step(1);
    per[0] = 8'h00; per[1] = 8'h05; dty[0] = 8'h00; dty[1] = 8'h02; step(1);
    en[1] = 1; tag = "R8 fused 0/1 small"; step(30);
    en = '0; step(1);
    per[0] = 8'h01; per[1] = 8'h00; dty[0] = 8'h00; dty[1] = 8'h03; step(1);
    en[1] = 1; tag = "R8 fused 0/1 large"; step(520);
    en = '0; step(2);
    cat = '0; step(3);

    @(negedge clk); @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule